// File: doc/BRIEF.md
# Quad DAC Load Controller

This block holds the digital side of four double-buffered DAC channels. A host writes a code into one of four channel input registers through a simple parallel write port. The code reaches that channel's active output register only when a load event happens. A configuration register sets the load policy and a per-channel output range bit. A write-only command register issues load pulses and chooses an internal or external reference for each channel pair.

There are two sources of load events. While the external active-low load pin is enabled, each falling edge on that pin refreshes all four channels. The pin goes through a two-stage synchroniser before the block looks for the edge. While the pin is disabled, the loads come from register activity, and a two-bit mode field picks one of four policies: each channel loads itself, a write to the second channel of a pair loads the whole pair, a write to the last channel loads all four, or only the command register loads. When a write also triggers a load of the same channel, the output takes the value being written.

Top module: `dac_load_ctrl`

## Requirements
- R1: A synchronous reset clears every input code, every output code, the configuration register and the reference bits to zero. It also leaves the pin synchroniser at the idle (high) level.
- R2: Address map: addresses 0 to 3 are the input registers of channels A to D (channel n at address n), address 4 is configuration and address 5 is the load command register. Configuration bits 3:0 drive `range_x2[3:0]` (bit n belongs to channel n, 1 = double range), and the register reads back at address 4.
- R3: With the pin disabled and mode field (configuration bits 5:4) = 00, a write to channel n updates only output n.
- R4: With the pin disabled and mode 01, a write to channel B updates outputs A and B, a write to channel D updates outputs C and D, and writes to A or C change no output.
- R5: With the pin disabled and mode 10, a write to channel D updates all four outputs, and writes to A, B or C change no output.
- R6: With the pin disabled and mode 11, channel writes change no output. A command-register write with bit n (0..3) set updates output n, and any combination of these bits acts in a single write.
- R7: Command bits 3:0 always read back as 0. Command bit 4 drives `ref_int[0]` (channels A and B), command bit 5 drives `ref_int[1]` (channels C and D), and both read back at bits 5:4 of address 5.
- R8: Bits 7:6 and every higher bit of addresses 4 and 5 always read as 0, whatever was written to them.
- R9: With the pin enabled (`load_pin_off` = 0), a falling edge on `load_n` updates all four outputs on the third rising clock edge after the change. Channel writes and command bits then update no output.
- R10: With the pin disabled, edges on `load_n` change no output.
- R11: An update and a write to the same channel's input register at the same edge make the output show the value written at that edge. The output updates on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | CODE_W | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | CODE_W | Read data, combinational |
| load_n | input | 1 | External load pin, active low, asynchronous |
| load_pin_off | input | 1 | 1 disables the pin and enables register-driven loads |
| dac_code | output | 4*CODE_W | Active output codes, channel n at bits n*CODE_W upward |
| range_x2 | output | 4 | Per-channel double-range select |
| ref_int | output | 2 | Internal reference select for pair A/B (bit 0) and C/D (bit 1) |

## Verification
A synchronised pin edge and a channel write can reach the load logic in the same clock cycle. To provoke this, the bench drives `load_n` low and then, after exactly two rising edges, presents a write to one channel, so that the write's edge is the one where the edge detector fires. The expected result is that every output takes its input code and that the written channel shows the new value rather than the old one. The bench judges this at the ports, and the same check is made for each channel.

// File: rtl/dac_ldc_pkg.sv
package dac_ldc_pkg;

   localparam int unsigned NCH = 4;

   localparam int unsigned ADDR_CFG = 4;
   localparam int unsigned ADDR_CMD = 5;

   typedef enum logic [1:0] {
      LD_SELF     = 2'b00,
      LD_PAIR     = 2'b01,
      LD_ALL_ON_D = 2'b10,
      LD_CMD      = 2'b11
   } ld_mode_e;

   typedef struct packed {
      logic [1:0] rsvd;
      ld_mode_e   mode;
      logic [3:0] range2x;
   } dac_cfg_t;

endpackage

// File: rtl/dac_ldc_pin_sync.sv
module dac_ldc_pin_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic pin_n,
   output logic fall
);

   if (STAGES < 2) begin : g_bad_stages
      $error("dac_ldc_pin_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sync_q;
   logic              last_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         sync_q <= '1;
         last_q <= 1'b1;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], pin_n};
         last_q <= sync_q[STAGES-1];
      end
   end

   assign fall = last_q & ~sync_q[STAGES-1];

endmodule

// File: rtl/dac_ldc_trig_dec.sv
module dac_ldc_trig_dec
   import dac_ldc_pkg::*;
#(
   parameter int unsigned ADDR_W = 3
) (
   input  logic              pin_off,
   input  logic              pin_fall,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [3:0]        cmd_bits,
   input  ld_mode_e          mode,
   output logic [NCH-1:0]    upd
);

   logic [NCH-1:0] ch_wr;
   logic           cmd_wr;

   for (genvar g = 0; g < NCH; g++) begin : g_sel
      assign ch_wr[g] = wr_en && (wr_addr == ADDR_W'(g));
   end
   assign cmd_wr = wr_en && (wr_addr == ADDR_W'(ADDR_CMD));

   always_comb begin
      upd = '0;
      if (!pin_off) begin
         upd = {NCH{pin_fall}};
      end else begin
         case (mode)
            LD_SELF:     upd = ch_wr;
            LD_PAIR:     upd = {{2{ch_wr[3]}}, {2{ch_wr[1]}}};
            LD_ALL_ON_D: upd = {NCH{ch_wr[3]}};
            default:     upd = cmd_wr ? cmd_bits : '0;
         endcase
      end
   end

endmodule

// File: rtl/dac_ldc_chan.sv
module dac_ldc_chan #(
   parameter int unsigned CODE_W = 12
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr,
   input  logic [CODE_W-1:0] wr_data,
   input  logic              upd,
   output logic [CODE_W-1:0] in_code,
   output logic [CODE_W-1:0] out_code
);

   logic [CODE_W-1:0] in_q, out_q, in_nxt;

   assign in_nxt = wr ? wr_data : in_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         in_q  <= '0;
         out_q <= '0;
      end else begin
         in_q <= in_nxt;
         if (upd) out_q <= in_nxt;
      end
   end

   assign in_code  = in_q;
   assign out_code = out_q;

endmodule

// File: rtl/dac_load_ctrl.sv
module dac_load_ctrl
   import dac_ldc_pkg::*;
#(
   parameter int unsigned CODE_W      = 12,
   parameter int unsigned ADDR_W      = 3,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  wr_en,
   input  logic [ADDR_W-1:0]     wr_addr,
   input  logic [CODE_W-1:0]     wr_data,
   input  logic [ADDR_W-1:0]     rd_addr,
   output logic [CODE_W-1:0]     rd_data,
   input  logic                  load_n,
   input  logic                  load_pin_off,
   output logic [4*CODE_W-1:0]   dac_code,
   output logic [3:0]            range_x2,
   output logic [1:0]            ref_int
);

   localparam int unsigned REG_W = 8;

   if (CODE_W < REG_W) begin : g_bad_code_w
      $error("dac_load_ctrl: CODE_W must be at least 8");
   end
   if (ADDR_W < 3) begin : g_bad_addr_w
      $error("dac_load_ctrl: ADDR_W must be at least 3");
   end

   dac_cfg_t            cfg_q;
   logic [1:0]          ref_q;
   logic                pin_fall;
   logic [NCH-1:0]      upd;
   logic [NCH*CODE_W-1:0] in_flat;
   logic                cfg_wr, cmd_wr;

   assign cfg_wr = wr_en && (wr_addr == ADDR_W'(ADDR_CFG));
   assign cmd_wr = wr_en && (wr_addr == ADDR_W'(ADDR_CMD));

   always_ff @(posedge clk) begin
      if (rst) begin
         cfg_q <= '0;
         ref_q <= '0;
      end else begin
         if (cfg_wr) begin
            cfg_q.rsvd    <= 2'b00;
            cfg_q.mode    <= ld_mode_e'(wr_data[5:4]);
            cfg_q.range2x <= wr_data[3:0];
         end
         if (cmd_wr) ref_q <= wr_data[5:4];
      end
   end

   dac_ldc_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst   (rst),
      .pin_n (load_n),
      .fall  (pin_fall)
   );

   dac_ldc_trig_dec #(.ADDR_W(ADDR_W)) u_dec (
      .pin_off  (load_pin_off),
      .pin_fall (pin_fall),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .cmd_bits (wr_data[3:0]),
      .mode     (cfg_q.mode),
      .upd      (upd)
   );

   for (genvar g = 0; g < NCH; g++) begin : g_ch
      logic ch_wr;
      assign ch_wr = wr_en && (wr_addr == ADDR_W'(g));
      dac_ldc_chan #(.CODE_W(CODE_W)) u_ch (
         .clk      (clk),
         .rst      (rst),
         .wr       (ch_wr),
         .wr_data  (wr_data),
         .upd      (upd[g]),
         .in_code  (in_flat[g*CODE_W +: CODE_W]),
         .out_code (dac_code[g*CODE_W +: CODE_W])
      );
   end

   always_comb begin
      rd_data = '0;
      for (int n = 0; n < NCH; n++) begin
         if (rd_addr == ADDR_W'(n)) rd_data = in_flat[n*CODE_W +: CODE_W];
      end
      if (rd_addr == ADDR_W'(ADDR_CFG)) rd_data = CODE_W'(cfg_q);
      if (rd_addr == ADDR_W'(ADDR_CMD)) rd_data = CODE_W'({2'b00, ref_q, 4'b0000});
   end

   assign range_x2 = cfg_q.range2x;
   assign ref_int  = ref_q;

endmodule

// File: rtl/dac_ldc_chk.sv
module dac_ldc_chk
   import dac_ldc_pkg::*;
#(
   parameter int unsigned CODE_W = 12,
   parameter int unsigned ADDR_W = 3
) (
   input logic                  clk,
   input logic                  rst,
   input logic                  wr_en,
   input logic [ADDR_W-1:0]     wr_addr,
   input logic [CODE_W-1:0]     wr_data,
   input logic [ADDR_W-1:0]     rd_addr,
   input logic [CODE_W-1:0]     rd_data,
   input logic                  load_pin_off,
   input logic [4*CODE_W-1:0]   dac_code,
   input logic [3:0]            range_x2,
   input logic [1:0]            ref_int,
   input ld_mode_e              mode,
   input logic                  pin_fall,
   input logic [4*CODE_W-1:0]   in_flat
);

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (dac_code == '0) && (range_x2 == 4'h0) && (ref_int == 2'b00));

   for (genvar g = 0; g < NCH; g++) begin : g_self
      // R3
      self_load_chk: assert property (@(posedge clk) disable iff (rst)
         (load_pin_off && wr_en && wr_addr == ADDR_W'(g) && mode == LD_SELF)
         |=> dac_code[g*CODE_W +: CODE_W] == $past(wr_data));
   end

   // R5
   all_on_d_chk: assert property (@(posedge clk) disable iff (rst)
      (load_pin_off && wr_en && wr_addr == ADDR_W'(3) && mode == LD_ALL_ON_D)
      |=> dac_code == in_flat);

   // R9
   pin_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      (!load_pin_off && !pin_fall) |=> $stable(dac_code));

   // R10
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (load_pin_off && !wr_en) |=> $stable(dac_code));

   // R8
   cfg_rsvd_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_addr == ADDR_W'(ADDR_CFG)) |-> (rd_data[CODE_W-1:6] == '0));

   // R7
   cmd_selfclr_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_addr == ADDR_W'(ADDR_CMD)) |-> (rd_data[3:0] == 4'h0));

endmodule

bind dac_load_ctrl dac_ldc_chk #(.CODE_W(CODE_W), .ADDR_W(ADDR_W)) u_chk (
   .clk          (clk),
   .rst          (rst),
   .wr_en        (wr_en),
   .wr_addr      (wr_addr),
   .wr_data      (wr_data),
   .rd_addr      (rd_addr),
   .rd_data      (rd_data),
   .load_pin_off (load_pin_off),
   .dac_code     (dac_code),
   .range_x2     (range_x2),
   .ref_int      (ref_int),
   .mode         (cfg_q.mode),
   .pin_fall     (pin_fall),
   .in_flat      (in_flat)
);

// File: tb/sim_dac_load_ctrl.sv
`timescale 1ns/1ps
module sim_dac_load_ctrl;

   localparam int CW = 12;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          wr_en = 1'b0;
   logic [2:0]    wr_addr = '0;
   logic [CW-1:0] wr_data = '0;
   logic [2:0]    rd_addr = '0;
   logic [CW-1:0] rd_data;
   logic          load_n = 1'b1;
   logic          load_pin_off = 1'b1;
   logic [4*CW-1:0] dac_code;
   logic [3:0]    range_x2;
   logic [1:0]    ref_int;

   always #2.5 clk = ~clk;

   dac_load_ctrl #(.CODE_W(CW), .ADDR_W(3), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .load_n(load_n),
      .load_pin_off(load_pin_off), .dac_code(dac_code),
      .range_x2(range_x2), .ref_int(ref_int)
   );

   int n_chk = 0;
   int n_fail = 0;
   logic [CW-1:0] m_in[4];
   logic [CW-1:0] m_out[4];
   logic [5:0]    m_cfg;
   logic [1:0]    m_ref;

   task automatic expect_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic check_all(input string req);
      for (int n = 0; n < 4; n++) expect_eq(req, 32'(dac_code[n*CW +: CW]), 32'(m_out[n]));
      expect_eq(req, 32'(range_x2), 32'(m_cfg[3:0]));
      expect_eq(req, 32'(ref_int), 32'(m_ref));
   endtask

   task automatic check_rd(input string req, input logic [2:0] a, input logic [CW-1:0] exp);
      rd_addr = a;
      #1;
      expect_eq(req, 32'(rd_data), 32'(exp));
   endtask

   function automatic void model_wr(input logic [2:0] a, input logic [CW-1:0] d);
      if (a < 3'd4) begin
         m_in[a] = d;
         if (load_pin_off) begin
            case (m_cfg[5:4])
               2'b00: m_out[a] = m_in[a];
               2'b01: begin
                  if (a == 3'd1) begin m_out[0] = m_in[0]; m_out[1] = m_in[1]; end
                  if (a == 3'd3) begin m_out[2] = m_in[2]; m_out[3] = m_in[3]; end
               end
               2'b10: if (a == 3'd3) for (int n = 0; n < 4; n++) m_out[n] = m_in[n];
               default: ;
            endcase
         end
      end else if (a == 3'd4) begin
         m_cfg = d[5:0];
      end else if (a == 3'd5) begin
         m_ref = d[5:4];
         if (load_pin_off && m_cfg[5:4] == 2'b11)
            for (int n = 0; n < 4; n++) if (d[n]) m_out[n] = m_in[n];
      end
   endfunction

   task automatic do_wr(input logic [2:0] a, input logic [CW-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      model_wr(a, d);
   endtask

   task automatic pin_pulse(input string req, input bit expect_load);
      @(negedge clk);
      load_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check_all(req);
      @(negedge clk);
      if (expect_load) for (int n = 0; n < 4; n++) m_out[n] = m_in[n];
      check_all(req);
      load_n = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      for (int n = 0; n < 4; n++) begin m_in[n] = '0; m_out[n] = '0; end
      m_cfg = '0; m_ref = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;

      // R1: reset state
      check_all("R1");
      for (int n = 0; n < 4; n++) check_rd("R1", 3'(n), '0);
      check_rd("R1", 3'd4, '0);
      check_rd("R1", 3'd5, '0);

      // R3 R4 R5 R6 R2 R11: sweep every mode, channel and several codes, pin disabled
      for (int md = 0; md < 4; md++) begin
         do_wr(3'd4, CW'((md << 4) | ((md * 5 + 3) & 15)));
         check_all("R2");
         check_rd("R2", 3'd4, CW'(m_cfg));
         for (int ch = 0; ch < 4; ch++) begin
            for (int k = 0; k < 3; k++) begin
               logic [CW-1:0] v;
               v = CW'(ch * 311 + k * 977 + md * 1409 + 1);
               do_wr(3'(ch), v);
               case (md)
                  0: check_all("R3 R11");
                  1: check_all("R4 R11");
                  2: check_all("R5 R11");
                  default: check_all("R6");
               endcase
               check_rd("R2", 3'(ch), v);
            end
         end
      end

      // R6 R7: every command combination in mode 11
      for (int c = 0; c < 16; c++) begin
         for (int ch = 0; ch < 4; ch++) do_wr(3'(ch), CW'(c * 53 + ch * 700 + 9));
         check_all("R6");
         do_wr(3'd5, CW'(((c & 3) << 4) | c));
         check_all("R6 R7");
         check_rd("R7", 3'd5, CW'({2'b00, m_ref, 4'b0000}));
      end

      // R8: reserved bits read as zero
      do_wr(3'd4, CW'('hFFF));
      check_rd("R8", 3'd4, CW'('h3F));
      do_wr(3'd5, CW'('hFF0));
      check_rd("R8", 3'd5, CW'('h30));
      check_all("R8");

      // R10: pin edges ignored while disabled
      do_wr(3'd4, CW'('h00));
      do_wr(3'd2, CW'('h0AB));
      do_wr(3'd4, CW'('h30));
      do_wr(3'd1, CW'('h5C5));
      pin_pulse("R10", 1'b0);

      // R9: pin enabled, register triggers ignored, falling edge loads all
      @(negedge clk);
      load_pin_off = 1'b0;
      do_wr(3'd4, CW'('h00));
      for (int ch = 0; ch < 4; ch++) begin
         do_wr(3'(ch), CW'(ch * 1000 + 77));
         check_all("R9");
      end
      do_wr(3'd4, CW'('h30));
      do_wr(3'd5, CW'('h0F));
      check_all("R9");
      pin_pulse("R9", 1'b1);

      // R9 R11: pin edge and channel write land on the same edge
      for (int ch = 0; ch < 4; ch++) begin
         @(negedge clk);
         load_n = 1'b0;
         @(negedge clk);
         @(negedge clk);
         wr_en = 1'b1; wr_addr = 3'(ch); wr_data = CW'(ch * 211 + 3001);
         @(negedge clk);
         wr_en = 1'b0;
         model_wr(3'(ch), CW'(ch * 211 + 3001));
         for (int n = 0; n < 4; n++) m_out[n] = m_in[n];
         check_all("R9 R11");
         load_n = 1'b1;
         repeat (3) @(negedge clk);
      end

      // R1: reset again after activity
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      for (int n = 0; n < 4; n++) begin m_in[n] = '0; m_out[n] = '0; end
      m_cfg = '0; m_ref = '0;
      check_all("R1");
      check_rd("R1", 3'd3, '0);

      summary();
      $finish;
   end

endmodule